// File: doc/BRIEF.md
# Satellite Physical-Layer Frame Assembler

The block wraps a stream of already mapped payload symbols into a physical-layer frame for a satellite downlink. Each frame opens with a 90-symbol header. The header carries a fixed 26-bit start marker, then a 64-bit signalling word that has been scrambled with a host-supplied 64-bit sequence. All 90 header bits are sent as pi/2-rotated BPSK. The payload follows in slots of 90 symbols. When the frame asks for pilots, a block of 36 unmodulated reference symbols is placed after every sixteenth slot, except after the final one.

A one-cycle start request captures the whole frame description: size bit, pilot bit, mapping order, signalling word and scrambling word. The block then emits the frame symbol by symbol on a valid/ready output. It pulls payload symbols through a valid/ready input only during data slots. Strobes on the output mark the first header symbol and the last symbol of the frame. Encoding the signalling word, mapping the payload and pulse shaping are done elsewhere.

Top module: `plframe_builder`

## Requirements
- R1: After reset, and between frames until a start request is taken, out_valid and pay_ready are 0 whatever the payload and output-ready inputs do.
- R2: Header positions 0..25 (position 0 sent first) carry the bits of 26'h18D2E82, most significant bit first; header position 0 is therefore bit value 0.
- R3: Header positions 26..89 carry sig_word[63-j] XOR scr_word[63-j] for j = position-26, i.e. both words are sent most significant bit first.
- R4: A header bit y at zero-based position k maps to level s = (1-2y)*A, where A is 1/sqrt(2) at full scale 2^(SW-1), rounded (23170 for SW=16). For even k, I = Q = s. For odd k, I = -s and Q = s.
- R5: The slot count is B/(90*m), where B is 64800 when cfg_short=0 and 16200 when cfg_short=1, and m = cfg_order+2 bits per symbol (order code 0..3 gives 4, 8, 16, 32 points). The frame carries exactly 90*slots payload symbols.
- R6: With cfg_pilots=1, a block of 36 symbols with I = Q = A follows data slot s (zero-based) whenever (s+1) is a multiple of 16 and s is not the last slot. That gives floor((slots-1)/16) blocks. With cfg_pilots=0 no pilot block appears.
- R7: A frame is 90 + 90*slots + 36*pilot_blocks output symbols. out_sof is high on exactly the first one and out_eof on exactly the last one.
- R8: Payload symbols appear on the output unchanged, in arrival order, with none dropped or repeated. pay_ready is 0 during header and pilot symbols and whenever out_ready is 0.
- R9: Changes to the configuration, signalling or scrambling inputs after the start request has been taken do not alter the frame in progress.
- R10: While out_valid is 1 and out_ready is 0, the output symbol and strobes hold steady on the next cycle, provided the payload source holds its offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Start request, taken while idle |
| cfg_short | input | 1 | Frame size: 0 = 64800 bits, 1 = 16200 bits |
| cfg_pilots | input | 1 | 1 = insert pilot blocks |
| cfg_order | input | 2 | Bits per payload symbol minus 2 |
| sig_word | input | SIG_BITS | Encoded signalling word |
| scr_word | input | SIG_BITS | Scrambling sequence for the signalling word |
| pay_valid | input | 1 | Payload symbol offered |
| pay_ready | output | 1 | Payload symbol accepted this cycle |
| pay_i | input | SW | Payload in-phase sample |
| pay_q | input | SW | Payload quadrature sample |
| out_valid | output | 1 | Output symbol valid |
| out_ready | input | 1 | Downstream accepts the output symbol |
| out_i | output | SW | Output in-phase sample (signed) |
| out_q | output | SW | Output quadrature sample (signed) |
| out_sof | output | 1 | First header symbol of a frame |
| out_eof | output | 1 | Last symbol of a frame |

## Verification
The bench sweeps every order code with and without pilots on short frames. It adds long frames for the smallest and a mid-size slot count. Every output symbol is compared against a position-by-position model, so an off-by-one in slot counting shows up as a missing or extra pilot block or a wrong frame length. A header bit taken from the wrong end of a word, or the two pi/2 phases swapped, shows up as a sign error on I or Q. Throttled output and gapped payload expose a design that loses or repeats payload symbols, or that changes its output under a stall. Configuration inputs are rewritten mid-frame to catch a design that reads them live instead of holding the values it captured at start.

// File: rtl/plf_pkg.sv
package plf_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_HDR   = 2'd1,
        PH_DATA  = 2'd2,
        PH_PILOT = 2'd3
    } plf_phase_e;

    localparam int unsigned      SOF_LEN     = 26;
    localparam logic [SOF_LEN-1:0] SOF_PATTERN = 26'h18D2E82;

    // 1/sqrt(2) at full scale 2^(w-1), rounded to the nearest code
    function automatic int amp_code(input int w);
        return int'(0.7071067811865476 * (2.0 ** (w - 1)));
    endfunction

endpackage

// File: rtl/plf_slot_calc.sv
module plf_slot_calc #(
    parameter int unsigned NORMAL_BITS = 64800,
    parameter int unsigned SHORT_BITS  = 16200,
    parameter int unsigned SLOT_SYMS   = 90,
    parameter int unsigned SLOT_W      = 9
) (
    input  logic              cfg_short,
    input  logic [1:0]        cfg_order,
    output logic [SLOT_W-1:0] slots
);
    localparam int unsigned N_ENTRIES = 8;

    logic [SLOT_W-1:0] count_tbl [N_ENTRIES];

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        localparam int unsigned FBITS = (g >= 4) ? SHORT_BITS : NORMAL_BITS;
        localparam int unsigned BPS   = (g % 4) + 2;
        localparam int unsigned CNT   = FBITS / (SLOT_SYMS * BPS);
        assign count_tbl[g] = SLOT_W'(CNT);
    end

    assign slots = count_tbl[{cfg_short, cfg_order}];

endmodule

// File: rtl/plf_hdr_map.sv
module plf_hdr_map
    import plf_pkg::*;
#(
    parameter int unsigned SW       = 16,
    parameter int unsigned SIG_BITS = 64,
    parameter int unsigned HDR_W    = 7
) (
    input  logic [HDR_W-1:0]     idx,
    input  logic [SIG_BITS-1:0]  scr_sig,
    output logic signed [SW-1:0] sym_i,
    output logic signed [SW-1:0] sym_q
);
    localparam int unsigned HDR_SYMS = SOF_LEN + SIG_BITS;
    localparam logic signed [SW-1:0] AMP = SW'(amp_code(SW));

    logic [HDR_SYMS-1:0]  hdr_bits;
    logic                 bit_y;
    logic signed [SW-1:0] lvl;

    assign hdr_bits = {SOF_PATTERN, scr_sig};

    always_comb begin
        bit_y = hdr_bits[HDR_W'(HDR_SYMS - 1) - idx];
        lvl   = bit_y ? -AMP : AMP;
        if (idx[0]) begin
            sym_i = -lvl;
            sym_q = lvl;
        end else begin
            sym_i = lvl;
            sym_q = lvl;
        end
    end

endmodule

// File: rtl/plf_sequencer.sv
module plf_sequencer
    import plf_pkg::*;
#(
    parameter int unsigned SIG_BITS    = 64,
    parameter int unsigned SLOT_W      = 9,
    parameter int unsigned SLOT_SYMS   = 90,
    parameter int unsigned PILOT_SYMS  = 36,
    parameter int unsigned PILOT_EVERY = 16,
    parameter int unsigned HDR_SYMS    = 90,
    parameter int unsigned HDR_W       = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                cfg_pilots,
    input  logic [SLOT_W-1:0]   slots_in,
    input  logic [SIG_BITS-1:0] sig_word,
    input  logic [SIG_BITS-1:0] scr_word,
    input  logic                advance,
    output plf_phase_e          phase,
    output logic [HDR_W-1:0]    hdr_idx,
    output logic [SIG_BITS-1:0] scr_sig,
    output logic                first_sym,
    output logic                last_sym
);
    localparam int unsigned SYM_W = $clog2(SLOT_SYMS);
    localparam int unsigned PIL_W = $clog2(PILOT_SYMS);
    localparam int unsigned GRP_W = $clog2(PILOT_EVERY);

    typedef struct packed {
        plf_phase_e          phase;
        logic [HDR_W-1:0]    hdr;
        logic [SYM_W-1:0]    sym;
        logic [SLOT_W-1:0]   slot;
        logic [GRP_W-1:0]    grp;
        logic [PIL_W-1:0]    pil;
        logic                pilots;
        logic [SLOT_W-1:0]   last_slot;
        logic [SIG_BITS-1:0] word;
    } seq_t;

    seq_t seq_d, seq_q;

    logic hdr_done, slot_done, pil_done, frame_done, grp_full;

    always_comb begin
        seq_d      = seq_q;
        hdr_done   = (seq_q.hdr == HDR_W'(HDR_SYMS - 1));
        slot_done  = (seq_q.sym == SYM_W'(SLOT_SYMS - 1));
        pil_done   = (seq_q.pil == PIL_W'(PILOT_SYMS - 1));
        frame_done = (seq_q.slot == seq_q.last_slot);
        grp_full   = (seq_q.grp == GRP_W'(PILOT_EVERY - 1));

        case (seq_q.phase)
            PH_IDLE: begin
                if (frame_start) begin
                    seq_d.phase     = PH_HDR;
                    seq_d.hdr       = '0;
                    seq_d.pilots    = cfg_pilots;
                    seq_d.last_slot = slots_in - SLOT_W'(1);
                    seq_d.word      = sig_word ^ scr_word;
                end
            end
            PH_HDR: begin
                if (advance) begin
                    if (hdr_done) begin
                        seq_d.phase = PH_DATA;
                        seq_d.sym   = '0;
                        seq_d.slot  = '0;
                        seq_d.grp   = '0;
                    end else begin
                        seq_d.hdr = seq_q.hdr + HDR_W'(1);
                    end
                end
            end
            PH_DATA: begin
                if (advance) begin
                    if (slot_done) begin
                        seq_d.sym = '0;
                        if (frame_done) begin
                            seq_d.phase = PH_IDLE;
                        end else begin
                            seq_d.slot = seq_q.slot + SLOT_W'(1);
                            seq_d.grp  = grp_full ? '0 : seq_q.grp + GRP_W'(1);
                            if (seq_q.pilots && grp_full) begin
                                seq_d.phase = PH_PILOT;
                                seq_d.pil   = '0;
                            end
                        end
                    end else begin
                        seq_d.sym = seq_q.sym + SYM_W'(1);
                    end
                end
            end
            PH_PILOT: begin
                if (advance) begin
                    if (pil_done) begin
                        seq_d.phase = PH_DATA;
                    end else begin
                        seq_d.pil = seq_q.pil + PIL_W'(1);
                    end
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase     = seq_q.phase;
    assign hdr_idx   = seq_q.hdr;
    assign scr_sig   = seq_q.word;
    assign first_sym = (seq_q.phase == PH_HDR) && (seq_q.hdr == '0);
    assign last_sym  = (seq_q.phase == PH_DATA) && frame_done && slot_done;

endmodule

// File: rtl/plframe_builder.sv
module plframe_builder
    import plf_pkg::*;
#(
    parameter int unsigned SW          = 16,
    parameter int unsigned SIG_BITS    = 64,
    parameter int unsigned NORMAL_BITS = 64800,
    parameter int unsigned SHORT_BITS  = 16200,
    parameter int unsigned SLOT_SYMS   = 90,
    parameter int unsigned PILOT_SYMS  = 36,
    parameter int unsigned PILOT_EVERY = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 cfg_short,
    input  logic                 cfg_pilots,
    input  logic [1:0]           cfg_order,
    input  logic [SIG_BITS-1:0]  sig_word,
    input  logic [SIG_BITS-1:0]  scr_word,
    input  logic                 pay_valid,
    output logic                 pay_ready,
    input  logic [SW-1:0]        pay_i,
    input  logic [SW-1:0]        pay_q,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic signed [SW-1:0] out_i,
    output logic signed [SW-1:0] out_q,
    output logic                 out_sof,
    output logic                 out_eof
);
    localparam int unsigned HDR_SYMS = SOF_LEN + SIG_BITS;
    localparam int unsigned HDR_W    = $clog2(HDR_SYMS);
    localparam int unsigned SLOT_W   = $clog2(NORMAL_BITS / (SLOT_SYMS * 2) + 1);
    localparam logic signed [SW-1:0] AMP = SW'(amp_code(SW));

    logic [SLOT_W-1:0]    slots_cfg;
    plf_phase_e           phase;
    logic [HDR_W-1:0]     hdr_idx;
    logic [SIG_BITS-1:0]  scr_sig;
    logic signed [SW-1:0] hdr_i, hdr_q;
    logic                 advance;

    plf_slot_calc #(
        .NORMAL_BITS (NORMAL_BITS),
        .SHORT_BITS  (SHORT_BITS),
        .SLOT_SYMS   (SLOT_SYMS),
        .SLOT_W      (SLOT_W)
    ) u_slot_calc (
        .cfg_short (cfg_short),
        .cfg_order (cfg_order),
        .slots     (slots_cfg)
    );

    plf_sequencer #(
        .SIG_BITS    (SIG_BITS),
        .SLOT_W      (SLOT_W),
        .SLOT_SYMS   (SLOT_SYMS),
        .PILOT_SYMS  (PILOT_SYMS),
        .PILOT_EVERY (PILOT_EVERY),
        .HDR_SYMS    (HDR_SYMS),
        .HDR_W       (HDR_W)
    ) u_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .cfg_pilots  (cfg_pilots),
        .slots_in    (slots_cfg),
        .sig_word    (sig_word),
        .scr_word    (scr_word),
        .advance     (advance),
        .phase       (phase),
        .hdr_idx     (hdr_idx),
        .scr_sig     (scr_sig),
        .first_sym   (out_sof),
        .last_sym    (out_eof)
    );

    plf_hdr_map #(
        .SW       (SW),
        .SIG_BITS (SIG_BITS),
        .HDR_W    (HDR_W)
    ) u_hdr_map (
        .idx     (hdr_idx),
        .scr_sig (scr_sig),
        .sym_i   (hdr_i),
        .sym_q   (hdr_q)
    );

    always_comb begin
        out_valid = 1'b0;
        out_i     = '0;
        out_q     = '0;
        case (phase)
            PH_HDR: begin
                out_valid = 1'b1;
                out_i     = hdr_i;
                out_q     = hdr_q;
            end
            PH_DATA: begin
                out_valid = pay_valid;
                out_i     = pay_i;
                out_q     = pay_q;
            end
            PH_PILOT: begin
                out_valid = 1'b1;
                out_i     = AMP;
                out_q     = AMP;
            end
            default: ;
        endcase
    end

    assign pay_ready = (phase == PH_DATA) && out_ready;
    assign advance   = out_valid && out_ready;

endmodule

// File: rtl/plf_checker.sv
module plf_checker
    import plf_pkg::*;
#(
    parameter int unsigned SW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic signed [SW-1:0] out_i,
    input logic signed [SW-1:0] out_q,
    input logic                 out_sof,
    input logic                 out_eof,
    input logic                 pay_valid,
    input logic                 pay_ready
);
    localparam logic signed [SW-1:0] AMP = SW'(amp_code(SW));

    logic in_frame;
    logic fire;

    assign fire = out_valid && out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
        end else if (fire) begin
            if (out_eof) begin
                in_frame <= 1'b0;
            end else if (out_sof) begin
                in_frame <= 1'b1;
            end
        end
    end

    AST_SOF_OPENS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && out_sof) |-> !in_frame); // R7

    AST_EOF_CLOSES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && out_eof) |-> in_frame); // R7

    AST_SOF_SYMBOL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_valid && out_i == AMP && out_q == AMP)); // R2

    AST_HDR_BLOCKS_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> !pay_ready); // R8

    AST_PAYLOAD_NEEDS_SINK: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready |-> out_ready); // R8

    AST_IDLE_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_frame && !out_sof) |-> (!pay_ready && !out_valid)); // R1

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !(pay_valid && pay_ready)) |=>
        (out_valid && $stable(out_i) && $stable(out_q) && $stable(out_sof) && $stable(out_eof))); // R10

endmodule

bind plframe_builder plf_checker #(.SW(SW)) u_plf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_i     (out_i),
    .out_q     (out_q),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .pay_valid (pay_valid),
    .pay_ready (pay_ready)
);

// File: tb/plframe_builder_bench.sv
`timescale 1ns/1ps
module plframe_builder_bench;
    localparam int SW = 16;
    localparam int WATCHDOG = 195000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic cfg_short = 1'b0, cfg_pilots = 1'b0;
    logic [1:0] cfg_order = 2'd0;
    logic [63:0] sig_word = '0, scr_word = '0;
    logic pay_valid = 1'b0;
    logic pay_ready;
    logic [SW-1:0] pay_i = '0, pay_q = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic signed [SW-1:0] out_i, out_q;
    logic out_sof, out_eof;

    always #2.5 clk = ~clk;

    plframe_builder u_plframe_builder (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_short(cfg_short), .cfg_pilots(cfg_pilots), .cfg_order(cfg_order),
        .sig_word(sig_word), .scr_word(scr_word),
        .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_i(pay_i), .pay_q(pay_q),
        .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q),
        .out_sof(out_sof), .out_eof(out_eof)
    );

    int nchk = 0, nerr = 0;
    int frames_done = 0;
    bit timeout = 1'b0;

    // expected frame description, captured by the bench at start
    bit exp_short, exp_pil, chg_flag, bp_on, gap_on;
    int exp_ord;
    logic [63:0] exp_sig, exp_scr;
    int amp;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_slots();
        int bits = exp_short ? 16200 : 64800;
        return bits / (90 * (exp_ord + 2));
    endfunction

    function automatic int exp_pilots();
        return exp_pil ? (exp_slots() - 1) / 16 : 0;
    endfunction

    function automatic int exp_total();
        return 90 + 90 * exp_slots() + 36 * exp_pilots();
    endfunction

    // region: 0 header, 1 data (didx), 2 pilot
    function automatic int region(input int pos, output int didx);
        int p, g, r;
        didx = 0;
        if (pos < 90) return 0;
        p = pos - 90;
        if (!exp_pil) begin didx = p; return 1; end
        g = p / 1476;
        r = p % 1476;
        if (r < 1440) begin didx = g * 1440 + r; return 1; end
        return 2;
    endfunction

    task automatic driver();
        int cyc = 0, pos = 0, base = 0;
        longint pay_cnt = 0;
        bit pay_fire = 0, out_fire, was_stall = 0;
        logic [SW-1:0] st_i = '0, st_q = '0;
        bit st_sof = 0, st_eof = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                timeout = 1'b1;
                chk(1'b0, "R7", "watchdog expired", cyc, WATCHDOG);
                return;
            end
            if (pay_fire) pay_cnt++;
            if (!pay_valid || pay_fire) begin
                pay_valid = gap_on ? (cyc % 7 != 2) : 1'b1;
                pay_i = SW'(pay_cnt);
                pay_q = ~SW'(pay_cnt);
            end
            out_ready = bp_on ? (cyc % 5 != 3) : 1'b1;
            #1;
            if (was_stall) begin
                chk(out_valid && out_i == st_i && out_q == st_q && out_sof == st_sof && out_eof == st_eof,
                    "R10", "held symbol after stall", {out_i, out_q}, {st_i, st_q});
            end
            out_fire = out_valid && out_ready;
            pay_fire = pay_valid && pay_ready;
            if (out_valid) begin
                int didx;
                int rg = region(pos, didx);
                if (rg != 1)
                    chk(!pay_ready, rg == 0 ? "R8 header" : "R8 pilot", "pay_ready", pay_ready, 0);
            end
            if (out_fire) begin
                int didx, rg, total;
                string tg;
                total = exp_total();
                rg = region(pos, didx);
                if (rg == 0) begin
                    logic [89:0] hb;
                    int s;
                    bit y;
                    hb = {26'h18D2E82, exp_sig ^ exp_scr};
                    y = hb[89 - pos];
                    s = y ? -amp : amp;
                    tg = (pos < 26) ? "R2 R4" : "R3 R4";
                    if (chg_flag) tg = {tg, " R9"};
                    chk(int'(out_i) == ((pos % 2 == 1) ? -s : s), tg, $sformatf("header I pos %0d", pos), out_i, (pos % 2 == 1) ? -s : s);
                    chk(int'(out_q) == s, tg, $sformatf("header Q pos %0d", pos), out_q, s);
                    if (pos == 0) base = int'(pay_cnt);
                end else if (rg == 2) begin
                    tg = chg_flag ? "R6 R9" : "R6";
                    chk(int'(out_i) == amp && int'(out_q) == amp, tg, $sformatf("pilot pos %0d", pos), out_i, amp);
                end else begin
                    logic [SW-1:0] e;
                    e = SW'(base + didx);
                    tg = chg_flag ? "R8 R9" : "R8";
                    chk(out_i == e && out_q == ~e, tg, $sformatf("payload %0d", didx), out_i, e);
                end
                chk(out_sof == (pos == 0), "R7", $sformatf("sof at pos %0d", pos), out_sof, pos == 0);
                chk(out_eof == (pos == total - 1), chg_flag ? "R7 R9" : "R7",
                    $sformatf("eof at pos %0d", pos), out_eof, pos == total - 1);
                if (out_eof || pos == total - 1) begin
                    chk(pos + 1 == total, "R5 R7", "frame length", pos + 1, total);
                    chk(int'(pay_cnt) + int'(pay_fire) - base == 90 * exp_slots(), "R5",
                        "payload symbols per frame", int'(pay_cnt) + int'(pay_fire) - base, 90 * exp_slots());
                    pos = 0;
                    frames_done++;
                end else begin
                    pos++;
                end
            end
            was_stall = out_valid && !out_ready;
            st_i = out_i; st_q = out_q; st_sof = out_sof; st_eof = out_eof;
        end
    endtask

    task automatic run_frame(input bit sh, input bit pil, input int ord,
                             input bit bp, input bit gap, input bit midchg, input int n);
        int target;
        @(negedge clk);
        cfg_short = sh; cfg_pilots = pil; cfg_order = 2'(ord);
        sig_word = 64'hF0E1D2C3B4A59687 ^ {32'(n * 977), 32'(n * 31)};
        scr_word = 64'h0123456789ABCDEF ^ {n[7:0], 56'h0};
        exp_short = sh; exp_pil = pil; exp_ord = ord;
        exp_sig = sig_word; exp_scr = scr_word;
        bp_on = bp; gap_on = gap;
        target = frames_done + 1;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        if (midchg) begin
            repeat (300) @(negedge clk);
            chg_flag = 1'b1;
            cfg_short = ~sh; cfg_pilots = ~pil; cfg_order = ~cfg_order;
            sig_word = ~sig_word; scr_word = scr_word ^ 64'h5555AAAA5555AAAA;
        end
        wait (frames_done == target || timeout);
        chg_flag = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(!out_valid && !pay_ready, "R1", "idle between frames", {out_valid, pay_ready}, 0);
    endtask

    initial begin
        amp = int'(0.7071067811865476 * 32768.0);
        chg_flag = 0; bp_on = 0; gap_on = 0;
        exp_short = 1; exp_pil = 0; exp_ord = 0; exp_sig = '0; exp_scr = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        fork
            driver();
        join_none
        repeat (3) @(negedge clk);
        #1;
        chk(!out_valid && !pay_ready && !out_sof && !out_eof, "R1", "reset state",
            {out_valid, pay_ready, out_sof, out_eof}, 0);
        for (int o = 0; o < 4 && !timeout; o++) begin
            for (int p = 0; p < 2 && !timeout; p++) begin
                run_frame(1'b1, p[0], o, o == 3, o == 3, 1'b0, o * 2 + p);
            end
        end
        if (!timeout) run_frame(1'b1, 1'b1, 0, 1'b1, 1'b1, 1'b1, 20);
        if (!timeout) run_frame(1'b0, 1'b1, 3, 1'b0, 1'b0, 1'b0, 21);
        if (!timeout) run_frame(1'b0, 1'b0, 2, 1'b0, 1'b1, 1'b0, 22);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule